// File: doc/BRIEF.md
# Debounced Two-Button Up/Down Counter

This block keeps an 8-bit count that two mechanical push-buttons control. One button steps the count up and the other steps it down. The count drives eight LED outputs directly. One free-running system clock, nominally 50 MHz, times every register. The raw button lines are sampled only as data and never act as clocks or as asynchronous controls.

Each button line passes through a two-flop synchroniser and then a stability timer. The timer accepts a new level only after the synchronised input has disagreed with the accepted level for a set number of consecutive cycles. The accepted level is registered once more, so a rising transition can be seen. The count moves only when exactly one button shows a fresh press in a cycle while the other button is fully at rest. Any other combination leaves the count as it is.

Top module: `updown_button_counter`

## Requirements
- R1: An active-high synchronous `rst` clears the count, both stability timers, both accepted levels, the previous-level registers and the synchroniser flops to zero, so `leds` reads 0 after reset.
- R2: A raw button level is accepted only after the synchronised input has disagreed with the accepted level for `SETTLE_CYCLES` consecutive cycles. A press applied before clock edge k is visible on `leds` after edge k+2+`SETTLE_CYCLES`, and not after edge k+1+`SETTLE_CYCLES`.
- R3: A disagreement that lasts fewer than `SETTLE_CYCLES` cycles restarts the stability timer and does not change the accepted level. A bouncing line therefore leaves the count unchanged.
- R4: Each accepted press of `btn_up_raw` adds exactly 1 to the count, in a single cycle.
- R5: Each accepted press of `btn_dn_raw` subtracts exactly 1 from the count, in a single cycle.
- R6: Holding a button down gives no further steps, and releasing it leaves the count unchanged.
- R7: The step is decoded from the 4-bit pattern {previous down, current down, previous up, current up}, using the accepted levels. Pattern 0001 increments, pattern 0100 decrements and every other pattern holds. When both buttons are pressed so that they are accepted in the same cycle, the count does not change.
- R8: Under the pattern of R7, a press of one button while the other is still held down does not change the count.
- R9: The count wraps modulo 2^`COUNT_W`: 255 plus one gives 0, and 0 minus one gives 255.
- R10: The count changes by at most one step per clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register updates on its rising edge |
| rst | input | 1 | Active-high synchronous reset |
| btn_up_raw | input | 1 | Raw, unsynchronised, bouncing increment button (1 = pressed) |
| btn_dn_raw | input | 1 | Raw, unsynchronised, bouncing decrement button (1 = pressed) |
| leds | output | COUNT_W (8) | Current count, one bit per LED |

## Verification
The bench builds the block with `SETTLE_CYCLES` set to 4 and `COUNT_W` kept at 8. With this short window the bench can check the exact acceptance latency edge by edge. It can also make bursts of 3 high cycles that fall one cycle short of acceptance and must be rejected. With the 8-bit width, both wrap points are one press away from zero. The default window of one million cycles, about 20 ms at 50 MHz, uses the same logic, so shortening the window changes no structure.

// File: rtl/updown_button_counter.sv
module updown_button_counter #(
  parameter int COUNT_W       = 8,
  parameter int SETTLE_CYCLES = 1_000_000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               btn_up_raw,
  input  logic               btn_dn_raw,
  output logic [COUNT_W-1:0] leds
);

  localparam int            TW   = $clog2(SETTLE_CYCLES + 1);
  localparam logic [TW-1:0] LAST = TW'(SETTLE_CYCLES - 1);

  // index 0: up button, index 1: down button
  logic [1:0]         meta;
  logic [1:0]         sync;
  logic [1:0]         level;
  logic [1:0]         level_q;
  logic [1:0][TW-1:0] timer;

  wire [1:0] raw = {btn_dn_raw, btn_up_raw};

  always_ff @(posedge clk) begin
    if (rst) begin
      meta    <= '0;
      sync    <= '0;
      level   <= '0;
      level_q <= '0;
      timer   <= '0;
    end else begin
      meta    <= raw;
      sync    <= meta;
      level_q <= level;
      for (int i = 0; i < 2; i++) begin
        if (sync[i] != level[i]) begin
          if (timer[i] == LAST) begin
            level[i] <= sync[i];
            timer[i] <= '0;
          end else begin
            timer[i] <= timer[i] + TW'(1);
          end
        end else begin
          timer[i] <= '0;
        end
      end
    end
  end

  wire [3:0] pattern = {level_q[1], level[1], level_q[0], level[0]};
  wire       step_up = (pattern == 4'b0001);
  wire       step_dn = (pattern == 4'b0100);

  always_ff @(posedge clk) begin
    if (rst)          leds <= '0;
    else if (step_up) leds <= leds + COUNT_W'(1);
    else if (step_dn) leds <= leds - COUNT_W'(1);
  end

endmodule

// File: rtl/updown_button_counter_checker.sv
module updown_button_counter_checker #(
  parameter int COUNT_W       = 8,
  parameter int SETTLE_CYCLES = 1_000_000,
  localparam int TW           = $clog2(SETTLE_CYCLES + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic [COUNT_W-1:0] leds,
  input logic [1:0]         sync,
  input logic [1:0]         level,
  input logic [1:0]         level_q,
  input logic [1:0][TW-1:0] timer
);

  localparam logic [TW-1:0] LAST = TW'(SETTLE_CYCLES - 1);

  wire fresh_up = level[0] && !level_q[0];
  wire fresh_dn = level[1] && !level_q[1];
  wire calm_up  = !level[0] && !level_q[0];
  wire calm_dn  = !level[1] && !level_q[1];

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (leds == '0 && level == 2'b00 && timer == '0));

  assert_accept_up_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(level[0]) |-> ($past(timer[0]) == LAST && $past(sync[0]) != $past(level[0])));

  assert_accept_dn_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(level[1]) |-> ($past(timer[1]) == LAST && $past(sync[1]) != $past(level[1])));

  assert_restart_up_R3: assert property (@(posedge clk) disable iff (rst)
    (sync[0] == level[0]) |=> (timer[0] == '0));

  assert_restart_dn_R3: assert property (@(posedge clk) disable iff (rst)
    (sync[1] == level[1]) |=> (timer[1] == '0));

  assert_inc_R4: assert property (@(posedge clk) disable iff (rst)
    (fresh_up && calm_dn) |=> (leds == $past(leds) + COUNT_W'(1)));

  assert_dec_R5: assert property (@(posedge clk) disable iff (rst)
    (fresh_dn && calm_up) |=> (leds == $past(leds) - COUNT_W'(1)));

  assert_both_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (fresh_up && fresh_dn) |=> $stable(leds));

  assert_single_step_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(leds) |-> (leds == $past(leds) + COUNT_W'(1) || leds == $past(leds) - COUNT_W'(1)));

endmodule

bind updown_button_counter updown_button_counter_checker #(
  .COUNT_W(COUNT_W),
  .SETTLE_CYCLES(SETTLE_CYCLES)
) u_checker (
  .clk(clk),
  .rst(rst),
  .leds(leds),
  .sync(sync),
  .level(level),
  .level_q(level_q),
  .timer(timer)
);

// File: tb/updown_button_counter_bench.sv
`timescale 1ns/1ps
module updown_button_counter_bench;

  localparam int SETTLE = 4;
  localparam int LAT    = SETTLE + 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       up  = 1'b0;
  logic       dn  = 1'b0;
  logic [7:0] leds;
  logic [7:0] model = 8'd0;

  int runs  = 0;
  int fails = 0;
  int ticks = 0;

  always #4 clk = ~clk;

  updown_button_counter #(.COUNT_W(8), .SETTLE_CYCLES(SETTLE)) u_updown_button_counter (
    .clk(clk), .rst(rst), .btn_up_raw(up), .btn_dn_raw(dn), .leds(leds)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] exp);
    runs++;
    if (leds !== exp) begin
      fails++;
      $display("FAIL %s: leds=%0d expected=%0d", tag, leds, exp);
    end
  endtask

  task automatic t_reset_R1;
    rst = 1'b1; up = 1'b0; dn = 1'b0;
    step(3);
    rst = 1'b0;
    model = 8'd0;
    step(1);
    check("R1 reset value", model);
  endtask

  task automatic t_latency_R2;
    up = 1'b1;
    step(LAT - 1);
    check("R2 not yet visible", model);
    step(1);
    model = model + 8'd1;
    check("R2 visible at latency", model);
    up = 1'b0;
    step(LAT);
    check("R6 release no step", model);
  endtask

  task automatic t_bounce_R3;
    for (int k = 0; k < 3; k++) begin
      up = 1'b1; step(SETTLE - 1);
      up = 1'b0; step(1);
    end
    for (int k = 0; k < 3; k++) begin
      dn = 1'b1; step(SETTLE - 1);
      dn = 1'b0; step(2);
    end
    step(LAT);
    check("R3 short bounces rejected", model);
  endtask

  task automatic t_up_presses_R4;
    for (int k = 0; k < 3; k++) begin
      up = 1'b1; step(LAT);
      up = 1'b0; step(LAT);
    end
    model = model + 8'd3;
    check("R4 three presses", model);
  endtask

  task automatic t_hold_R6;
    up = 1'b1;
    step(LAT);
    model = model + 8'd1;
    check("R6 first step on hold", model);
    step(40);
    check("R6 no repeat while held", model);
    up = 1'b0;
    step(LAT);
    check("R6 release after hold", model);
  endtask

  task automatic t_down_R5;
    dn = 1'b1; step(LAT);
    model = model - 8'd1;
    check("R5 decrement", model);
    dn = 1'b0; step(LAT);
    check("R5 release", model);
  endtask

  task automatic t_both_R7;
    up = 1'b1; dn = 1'b1;
    step(LAT + 4);
    check("R7 simultaneous press holds", model);
    up = 1'b0; dn = 1'b0;
    step(LAT + 4);
    check("R7 simultaneous release holds", model);
  endtask

  task automatic t_other_held_R8;
    dn = 1'b1; step(LAT);
    model = model - 8'd1;
    check("R8 down held first", model);
    up = 1'b1; step(LAT + 4);
    check("R8 up while down held", model);
    up = 1'b0; step(LAT);
    dn = 1'b0; step(LAT);
    check("R8 after both released", model);
  endtask

  task automatic t_wrap_R9;
    dn = 1'b1; step(LAT);
    model = 8'd255;
    check("R9 wrap below zero", model);
    dn = 1'b0; step(LAT);
    up = 1'b1; step(LAT);
    model = 8'd0;
    check("R9 wrap above max", model);
    up = 1'b0; step(LAT);
  endtask

  task automatic t_reset_mid_R1;
    up = 1'b1; step(LAT);
    up = 1'b0; step(LAT);
    up = 1'b1; step(LAT);
    up = 1'b0; step(LAT);
    model = model + 8'd2;
    check("R1 pre-reset value", model);
    rst = 1'b1; step(2);
    rst = 1'b0;
    model = 8'd0;
    step(1);
    check("R1 mid-run reset clears", model);
  endtask

  initial begin
    t_reset_R1;
    t_latency_R2;
    t_up_presses_R4;
    t_hold_R6;
    t_bounce_R3;
    t_down_R5;
    t_both_R7;
    t_other_held_R8;
    t_reset_mid_R1;
    t_wrap_R9;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  always @(posedge clk) begin
    ticks++;
    if (ticks > 20000) begin
      runs++;
      fails++;
      $display("FAIL watchdog: cycles=%0d expected<=%0d", ticks, 20000);
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

endmodule